// File: doc/BRIEF.md
# ADC Conversion Sequencer with Control/Status Byte

This block runs conversions for an analog-to-digital converter. It holds one control/status byte that software writes and reads over a simple bus port. A conversion starts in one of two ways: software writes one to the start bit, or the auto-trigger mode sees a rising edge on a trigger line picked by a select field. While a conversion runs, the block sends the converter a clock divided down from the system clock. When the converter reports completion, the block raises a completion flag and, if enabled, an interrupt request.

The completion flag clears in two ways: software writes one to the flag bit, or the interrupt controller pulses an acknowledge when it takes the vector. A three-bit prescale field sets the divider ratio. A new ratio is loaded only when the free-running divider counter wraps, so a clock period already in progress is never cut short.

Control byte layout: bit 7 start/busy, bit 6 auto-trigger enable, bit 5 completion flag, bit 4 interrupt enable, bit 3 reserved (reads 0), bits 2:0 prescale code.

Top module: `adc_seq_ctrl`

## Requirements
- R1: A bus write with bit 7 = 1 while idle makes bit 7 read 1 and `conv_start` pulse high for exactly one cycle, both in the cycle after the write edge. Bit 7 stays 1 until the conversion completes.
- R2: Writing 0 to bit 7 never aborts a running conversion. Writing 1 to bit 7 while busy produces no second `conv_start` pulse.
- R3: With bit 6 = 1 and the block idle, a rising edge on `trig_in[trig_sel]` starts a conversion: bit 7 reads 1 and `conv_start` pulses two cycles after the edge enters. Edges are ignored when bit 6 = 0, when they arrive during a running conversion, or when they are on a line that is not selected.
- R4: A `conv_done` pulse during a conversion sets bit 5 and clears bit 7 in the next cycle. A `conv_done` pulse while idle has no effect.
- R5: `irq` is 1 exactly when bit 5, bit 4 and `gie` are all 1.
- R6: Bit 5 is cleared by writing 1 to it or by a pulse on `irq_ack`. Writing 0 to it leaves it unchanged. If a clear and a completion happen in the same cycle, the flag ends up set.
- R7: The prescale code in bits 2:0 sets the `conv_clk` period in system cycles: 0→2, 1→2, 2→4, 3→8, 4→16, 5→32, 6→64, 7→128. The clock is high for half of each period. A new code takes effect at the next wrap of the divider counter.
- R8: `conv_clk` is held low whenever no conversion is running.
- R9: After reset the control byte reads 0x00, and `irq`, `conv_start` and `conv_clk` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the control byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Current control/status byte |
| trig_sel | input | 3 | Selects which trigger line is used for auto-start |
| trig_in | input | 8 | Trigger lines |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge pulse; clears the flag |
| conv_done | input | 1 | Completion pulse from the converter |
| conv_clk | output | 1 | Divided converter clock, gated by busy |
| conv_start | output | 1 | One-cycle pulse when a conversion begins |
| irq | output | 1 | Interrupt request |

## Verification
Bus writes and `conv_done` take effect one cycle after the edge that samples them. A trigger edge starts a conversion two cycles after it enters, because it passes through one sampling register before the edge compare. `irq` follows the flag, the enable bit and `gie` with no added delay. The bench drives every input on the falling clock edge and samples on the following falling edge, which is one register stage later, or two for trigger tests. Each divider ratio is measured by counting falling-edge samples of `conv_clk` across one full high phase and one full low phase. The count starts only after enough cycles have passed for a new code to be loaded at a counter wrap.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int unsigned PS_W   = 3;
  localparam int unsigned DIV_W  = (1 << PS_W);
  localparam int unsigned BYTE_W = 8;

  localparam int unsigned B_START = 7;
  localparam int unsigned B_AUTO  = 6;
  localparam int unsigned B_FLAG  = 5;
  localparam int unsigned B_IEN   = 4;
  localparam int unsigned B_RSV   = 3;

  typedef struct packed {
    logic            busy;
    logic            auto_en;
    logic            flag;
    logic            irq_en;
    logic [PS_W-1:0] ps;
  } ctrl_t;

  function automatic logic [DIV_W-1:0] div_ratio(input logic [PS_W-1:0] ps);
    if (ps <= 1)
      return DIV_W'(2);
    else
      return DIV_W'(1) << ps;
  endfunction

  function automatic logic [BYTE_W-1:0] pack_ctrl(input ctrl_t c);
    logic [BYTE_W-1:0] b;
    b          = '0;
    b[B_START] = c.busy;
    b[B_AUTO]  = c.auto_en;
    b[B_FLAG]  = c.flag;
    b[B_IEN]   = c.irq_en;
    b[PS_W-1:0] = c.ps;
    return b;
  endfunction

endpackage

// File: rtl/adc_trig_edge.sv
module adc_trig_edge #(
  parameter int unsigned N_TRIG = 8,
  localparam int unsigned SEL_W = (N_TRIG > 1) ? $clog2(N_TRIG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_TRIG-1:0] trig_in,
  input  logic [SEL_W-1:0]  trig_sel,
  output logic              rise_o
);

  logic cur_q;
  logic prev_q;
  logic sel_bit;

  assign sel_bit = trig_in[trig_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      cur_q  <= sel_bit;
      prev_q <= cur_q;
    end
  end

  assign rise_o = cur_q & ~prev_q;

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o); // R3

endmodule

// File: rtl/adc_prescaler.sv
module adc_prescaler
  import adc_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PS_W-1:0] ps,
  input  logic            gate_en,
  output logic            conv_clk,
  output logic            wrap_o
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] ratio_q;
  logic [DIV_W-1:0] half;
  logic             phase;

  assign wrap_o = (cnt_q == ratio_q - DIV_W'(1));
  assign half   = ratio_q >> 1;
  assign phase  = (cnt_q >= half);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ratio_q <= DIV_W'(2);
    end else if (wrap_o) begin
      cnt_q   <= '0;
      ratio_q <= div_ratio(ps);
    end else begin
      cnt_q   <= cnt_q + DIV_W'(1);
    end
  end

  assign conv_clk = gate_en & phase;

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < ratio_q); // R7

  AST_RATIO_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_o |=> $stable(ratio_q)); // R7

  AST_GATED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_en |-> !conv_clk); // R8

endmodule

// File: rtl/adc_ctrl_reg.sv
module adc_ctrl_reg
  import adc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [BYTE_W-1:0] bus_wdata,
  input  logic              trig_rise,
  input  logic              conv_done,
  input  logic              irq_ack,
  input  logic              gie,
  output ctrl_t             ctrl_q,
  output logic              start_pls,
  output logic              irq
);

  logic start_sw;
  logic start_hw;
  logic start_now;
  logic finish_now;
  logic flag_clr;
  logic unused_rsv;

  assign unused_rsv = bus_wdata[B_RSV];

  assign start_sw   = bus_wr & bus_wdata[B_START];
  assign start_hw   = trig_rise & ctrl_q.auto_en;
  assign start_now  = ~ctrl_q.busy & (start_sw | start_hw);
  assign finish_now = ctrl_q.busy & conv_done;
  assign flag_clr   = irq_ack | (bus_wr & bus_wdata[B_FLAG]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      start_pls <= 1'b0;
    end else begin
      start_pls <= start_now;
      if (bus_wr) begin
        ctrl_q.auto_en <= bus_wdata[B_AUTO];
        ctrl_q.irq_en  <= bus_wdata[B_IEN];
        ctrl_q.ps      <= bus_wdata[PS_W-1:0];
      end
      if (start_now)
        ctrl_q.busy <= 1'b1;
      else if (finish_now)
        ctrl_q.busy <= 1'b0;
      if (finish_now)
        ctrl_q.flag <= 1'b1;
      else if (flag_clr)
        ctrl_q.flag <= 1'b0;
    end
  end

  assign irq = ctrl_q.flag & ctrl_q.irq_en & gie;

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_pls |=> !start_pls); // R1

  AST_START_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_pls |-> ctrl_q.busy); // R1

  AST_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.busy && !conv_done) |=> ctrl_q.busy); // R2

  AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.busy && conv_done) |=> (ctrl_q.flag && !ctrl_q.busy)); // R4

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !(ctrl_q.busy && conv_done)) |=> !ctrl_q.flag); // R6

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned N_TRIG = 8,
  localparam int unsigned SEL_W = (N_TRIG > 1) ? $clog2(N_TRIG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic [SEL_W-1:0]  trig_sel,
  input  logic [N_TRIG-1:0] trig_in,
  input  logic              gie,
  input  logic              irq_ack,
  input  logic              conv_done,
  output logic              conv_clk,
  output logic              conv_start,
  output logic              irq
);

  ctrl_t ctrl_q;
  logic  trig_rise;
  logic  div_wrap;

  adc_trig_edge #(.N_TRIG(N_TRIG)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig_in  (trig_in),
    .trig_sel (trig_sel),
    .rise_o   (trig_rise)
  );

  adc_ctrl_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .trig_rise (trig_rise),
    .conv_done (conv_done),
    .irq_ack   (irq_ack),
    .gie       (gie),
    .ctrl_q    (ctrl_q),
    .start_pls (conv_start),
    .irq       (irq)
  );

  adc_prescaler u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .ps       (ctrl_q.ps),
    .gate_en  (ctrl_q.busy),
    .conv_clk (conv_clk),
    .wrap_o   (div_wrap)
  );

  assign bus_rdata = pack_ctrl(ctrl_q);

  AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> !irq); // R5

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> bus_rdata[B_FLAG]); // R5

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rdata[B_RSV]); // R9

  AST_WRAP_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    div_wrap |=> !conv_clk); // R7

endmodule

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int CONV_CYC   = 4;
  localparam int WD_LIMIT   = 150000;
  localparam int EXP_DIV [8] = '{2, 2, 4, 8, 16, 32, 64, 128};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [2:0] trig_sel = 3'd0;
  logic [7:0] trig_in = 8'h00;
  logic       gie = 1'b0;
  logic       irq_ack = 1'b0;
  logic       man_done = 1'b0;
  logic       stub_done = 1'b0;
  logic       conv_done;
  logic       conv_clk;
  logic       conv_start;
  logic       irq;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  assign conv_done = man_done | stub_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_seq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .trig_sel(trig_sel), .trig_in(trig_in),
    .gie(gie), .irq_ack(irq_ack), .conv_done(conv_done),
    .conv_clk(conv_clk), .conv_start(conv_start), .irq(irq)
  );

  // converter model: counts rising edges of conv_clk after a start
  logic run = 1'b0;
  logic prev_cc = 1'b0;
  int   ccnt = 0;
  always @(negedge clk) begin
    stub_done <= 1'b0;
    if (conv_start) begin
      run <= 1'b1; ccnt <= 0; prev_cc <= conv_clk;
      if (conv_clk) ccnt <= 1;
    end else if (run) begin
      prev_cc <= conv_clk;
      if (conv_clk && !prev_cc) begin
        if (ccnt == CONV_CYC - 1) begin
          stub_done <= 1'b1; run <= 1'b0;
        end else ccnt <= ccnt + 1;
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WD_LIMIT) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: act cycles=%0d exp <=%0d", cyc, WD_LIMIT);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0; bus_wdata = 8'h00;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && bus_rdata[7]; i++) @(negedge clk);
  endtask

  int hi_n, lo_n, starts;

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(bus_rdata == 8'h00, "R9 rdata", bus_rdata, 0);
    chk(irq == 1'b0, "R9 irq", irq, 0);
    chk(conv_start == 1'b0, "R9 conv_start", conv_start, 0);
    chk(conv_clk == 1'b0, "R9 conv_clk", conv_clk, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R8 idle clock low across a full period
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(conv_clk == 1'b0, "R8 idle conv_clk", conv_clk, 0);
    end

    // R1 software start
    wr_ctrl(8'h80);
    chk(bus_rdata[7] == 1'b1, "R1 busy after write", bus_rdata[7], 1);
    chk(conv_start == 1'b1, "R1 start pulse", conv_start, 1);
    @(negedge clk);
    chk(conv_start == 1'b0, "R1 pulse one cycle", conv_start, 0);
    // R2 write zero / write one while busy
    wr_ctrl(8'h00);
    chk(bus_rdata[7] == 1'b1, "R2 zero keeps busy", bus_rdata[7], 1);
    starts = 0;
    @(negedge clk); bus_wr = 1'b1; bus_wdata = 8'h80;
    @(negedge clk); bus_wr = 1'b0; bus_wdata = 8'h00;
    if (conv_start) starts++;
    chk(starts == 0, "R2 no restart", starts, 0);
    wait_idle();
    chk(bus_rdata[7] == 1'b0, "R1 busy clears at done", bus_rdata[7], 0);
    chk(bus_rdata[5] == 1'b1, "R4 flag set", bus_rdata[5], 1);

    // R6 write zero leaves flag, R5 gating
    wr_ctrl(8'h10);
    chk(bus_rdata[5] == 1'b1, "R6 write0 keeps flag", bus_rdata[5], 1);
    chk(irq == 1'b0, "R5 gie=0 blocks", irq, 0);
    gie = 1'b1; #1;
    chk(irq == 1'b1, "R5 all set", irq, 1);
    wr_ctrl(8'h00);
    chk(irq == 1'b0, "R5 ie=0 blocks", irq, 0);
    wr_ctrl(8'h30);
    chk(bus_rdata[5] == 1'b0, "R6 write1 clears", bus_rdata[5], 0);
    chk(irq == 1'b0, "R5 flag=0 blocks", irq, 0);

    // R6 acknowledge clears
    wr_ctrl(8'h90); wait_idle();
    chk(irq == 1'b1, "R5 irq after done", irq, 1);
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    chk(bus_rdata[5] == 1'b0, "R6 ack clears", bus_rdata[5], 0);

    // R4 done while idle ignored
    @(negedge clk); man_done = 1'b1;
    @(negedge clk); man_done = 1'b0;
    chk(bus_rdata[5] == 1'b0, "R4 idle done ignored", bus_rdata[5], 0);

    // R6 clear coinciding with completion: set wins
    wr_ctrl(8'h80);
    @(negedge clk); bus_wr = 1'b1; bus_wdata = 8'h20; man_done = 1'b1;
    @(negedge clk); bus_wr = 1'b0; bus_wdata = 8'h00; man_done = 1'b0;
    chk(bus_rdata[5] == 1'b1, "R6 set beats clear", bus_rdata[5], 1);
    chk(bus_rdata[7] == 1'b0, "R4 busy cleared", bus_rdata[7], 0);
    repeat (20) @(negedge clk);
    wr_ctrl(8'h20);

    // R3 auto trigger
    trig_sel = 3'd3;
    wr_ctrl(8'h40);
    @(negedge clk); trig_in[3] = 1'b1;
    @(negedge clk);
    chk(conv_start == 1'b0, "R3 not yet", conv_start, 0);
    @(negedge clk);
    chk(conv_start == 1'b1, "R3 trig start", conv_start, 1);
    chk(bus_rdata[7] == 1'b1, "R3 busy", bus_rdata[7], 1);
    starts = 0;
    trig_in[3] = 1'b0; @(negedge clk); trig_in[3] = 1'b1;
    for (int i = 0; i < 2000 && bus_rdata[7]; i++) begin
      @(negedge clk); if (conv_start) starts++;
    end
    repeat (3) @(negedge clk);
    chk(starts == 0 && bus_rdata[7] == 1'b0, "R3 busy edge ignored", starts, 0);
    trig_in[3] = 1'b0;
    // unselected line
    @(negedge clk); trig_in[5] = 1'b1;
    repeat (3) @(negedge clk);
    chk(bus_rdata[7] == 1'b0, "R3 other line ignored", bus_rdata[7], 0);
    trig_in[5] = 1'b0;
    // auto disabled
    wr_ctrl(8'h20);
    @(negedge clk); trig_in[3] = 1'b1;
    repeat (3) @(negedge clk);
    chk(bus_rdata[7] == 1'b0, "R3 auto off ignored", bus_rdata[7], 0);
    trig_in[3] = 1'b0;

    // R7 divider ratio table
    for (int k = 0; k < 8; k++) begin
      wr_ctrl(8'(k));
      repeat (140) @(negedge clk);
      wr_ctrl(8'h80 | 8'(k));
      for (int i = 0; i < 300 && conv_clk; i++) @(negedge clk);
      for (int i = 0; i < 300 && !conv_clk; i++) @(negedge clk);
      hi_n = 0; lo_n = 0;
      while (conv_clk && hi_n < 300) begin hi_n++; @(negedge clk); end
      while (!conv_clk && lo_n < 300) begin lo_n++; @(negedge clk); end
      chk(hi_n == EXP_DIV[k] / 2, $sformatf("R7 high ps=%0d", k), hi_n, EXP_DIV[k] / 2);
      chk(hi_n + lo_n == EXP_DIV[k], $sformatf("R7 period ps=%0d", k), hi_n + lo_n, EXP_DIV[k]);
      wait_idle();
      @(negedge clk);
      chk(conv_clk == 1'b0, "R8 low after done", conv_clk, 0);
      wr_ctrl(8'h20);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule